// File: doc/BRIEF.md
# SPI FIFO Flag and Request Unit

This block sits beside the transmit and receive FIFOs of an SPI controller and turns their fill levels and the shifter's events into a status word, a single interrupt line and two DMA request lines. Each FIFO's level is compared with its own programmable watermark. When the transmit FIFO has drained to its mark, the unit asks for more data. When the receive FIFO has filled past its mark, it reports that data is waiting.

Events from the shift engine are held in sticky flags that software clears by writing ones. The events are a finished frame, the end of a busy period, a pop from an empty transmit FIFO and a push into a full receive FIFO. Writes to the control register also produce one-cycle flush pulses for the two FIFOs and set the module enable, which gates both DMA requests. All register writes use one select-and-data port.

The FIFO storage and the serial shifter are outside this block. It only observes their counts and strobes.

Top module: `spi_fifo_flags`

Write select codes: 0 control, 1 status (write-one-to-clear), 2 interrupt enable, 3 DMA enable, 4 watermarks. DEPTH defaults to 16, so each count port is 5 bits wide and each watermark is 4 bits wide.

## Requirements
- R1: After reset, the status word is 0x0000_0001 when both counts are zero and busy is low. The interrupt line, both DMA requests and both flush pulses are low, and the receive status word reads 0x0000_0002.
- R2: Status bit 0 is high exactly while the transmit count is at or below the transmit watermark. That watermark is held in bits [WM_W-1:0] of the watermark register (select 4).
- R3: Status bit 1 is high exactly while the receive count is strictly above the receive watermark. That watermark is held in watermark register bits starting at bit 16.
- R4: A frame-complete pulse sets sticky status bit 9. A falling edge of busy sets sticky status bit 10. Both flags stay set until cleared.
- R5: Writing the status select with a 1 in any of bits 8 to 13 clears those sticky flags. Zero bits leave the flags unchanged. A flag whose set event arrives in the same cycle as its clear stays set.
- R6: A transmit pop while the transmit count is 0 sets sticky bit 11. A receive push while the receive count equals DEPTH sets sticky bit 12. Strobes at any other count set nothing.
- R7: Status bit 24 follows the busy input.
- R8: The interrupt line is the registered OR, one cycle after the status change, of (status AND enable) over bits 0, 1, 9 and 10 of the interrupt-enable register (select 2). Enable bits at other positions have no effect.
- R9: The transmit DMA request equals control bit 0 AND DMA-enable bit 0 AND status bit 0. The receive DMA request equals control bit 0 AND DMA-enable bit 1 AND status bit 1. There is no register stage.
- R10: A control write with bit 8 set makes the transmit flush pulse high for exactly the one cycle after the write. Bit 9 does the same for the receive flush pulse.
- R11: The FIFO status word carries the transmit count in bits [7:0] and the receive count in bits [23:16]. Bit 1 of the receive status word is high while the receive count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_count_i | input | CNT_W | Transmit FIFO entry count |
| rx_count_i | input | CNT_W | Receive FIFO entry count |
| tx_pop_i | input | 1 | Shifter pops the transmit FIFO |
| rx_push_i | input | 1 | Shifter pushes the receive FIFO |
| frame_done_i | input | 1 | Frame-complete pulse from the shifter |
| busy_i | input | 1 | Shifter busy level |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select code |
| wr_data_i | input | 32 | Register write data |
| status_o | output | 32 | Status word |
| fifo_stat_o | output | 32 | FIFO count word |
| rx_stat_o | output | 32 | Receive status word |
| irq_o | output | 1 | Combined interrupt request |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_flush_o | output | 1 | Transmit FIFO flush pulse |
| rx_flush_o | output | 1 | Receive FIFO flush pulse |

## Verification
The assertions assume the following about the inputs:
- The count inputs never exceed DEPTH.
- The event strobes are synchronous to the clock.
- A status write and a flag's set event may coincide, with set taking priority.

The bench drives counts, strobes and writes only on the falling clock edge and keeps every count within 0 to DEPTH. It deliberately lines up a frame pulse with a clearing write to cover the priority case.

// File: rtl/spi_fsu_pkg.sv
package spi_fsu_pkg;
   typedef enum logic [2:0] {
      SEL_CTRL  = 3'd0,
      SEL_STAT  = 3'd1,
      SEL_IEN   = 3'd2,
      SEL_DMA   = 3'd3,
      SEL_WMARK = 3'd4
   } fsu_sel_e;

   // status bit positions (enables share them)
   localparam int B_TDR  = 0;
   localparam int B_RDR  = 1;
   localparam int B_FRM  = 9;
   localparam int B_XFR  = 10;
   localparam int B_TXU  = 11;
   localparam int B_RXO  = 12;
   localparam int B_BUSY = 24;

   // sticky window
   localparam int STK_LO = 8;
   localparam int STK_N  = 6;

   // control bits
   localparam int C_EN   = 0;
   localparam int C_TXFL = 8;
   localparam int C_RXFL = 9;

   // watermark field offset for receive side
   localparam int WM_RX_LSB = 16;
endpackage

// File: rtl/spi_fsu_level.sv
module spi_fsu_level #(
   parameter int CNT_W = 5,
   parameter int WM_W  = 4,
   parameter bit ABOVE = 1'b0
) (
   input  logic [CNT_W-1:0] count,
   input  logic [WM_W-1:0]  wmark,
   output logic             hit
);
   localparam int W = (CNT_W > WM_W) ? CNT_W : WM_W;

   logic [W-1:0] cnt_x, wm_x;
   assign cnt_x = W'(count);
   assign wm_x  = W'(wmark);

   generate
      if (ABOVE) begin : g_above
         assign hit = cnt_x > wm_x;
      end else begin : g_at_or_below
         assign hit = cnt_x <= wm_x;
      end
   endgenerate
endmodule

// File: rtl/spi_fsu_sticky.sv
module spi_fsu_sticky #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)      flag[i] <= 1'b0;
            else if (set[i]) flag[i] <= 1'b1;
            else if (clr[i]) flag[i] <= 1'b0;
         end
      end
   endgenerate

   // R4 / R5: a set event always leaves its flag high next cycle
   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((flag & $past(set)) == $past(set)));

   // R5: a clear without a set leaves the flag low
   p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & ~set) != '0) |=> ((flag & $past(clr & ~set)) == '0));
endmodule

// File: rtl/spi_fsu_cfg.sv
module spi_fsu_cfg
   import spi_fsu_pkg::*;
#(
   parameter int WM_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [31:0]      wr_data,
   output logic             mod_en,
   output logic [3:0]       ien,
   output logic [1:0]       dma_en,
   output logic [WM_W-1:0]  tx_wm,
   output logic [WM_W-1:0]  rx_wm,
   output logic             tx_flush,
   output logic             rx_flush,
   output logic [STK_N-1:0] stat_clr
);
   fsu_sel_e sel;
   assign sel = fsu_sel_e'(wr_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mod_en   <= 1'b0;
         ien      <= '0;
         dma_en   <= '0;
         tx_wm    <= '0;
         rx_wm    <= '0;
         tx_flush <= 1'b0;
         rx_flush <= 1'b0;
      end else begin
         tx_flush <= 1'b0;
         rx_flush <= 1'b0;
         if (wr_en) begin
            case (sel)
               SEL_CTRL: begin
                  mod_en   <= wr_data[C_EN];
                  tx_flush <= wr_data[C_TXFL];
                  rx_flush <= wr_data[C_RXFL];
               end
               SEL_IEN:  ien <= {wr_data[B_XFR], wr_data[B_FRM],
                                 wr_data[B_RDR], wr_data[B_TDR]};
               SEL_DMA:  dma_en <= wr_data[1:0];
               SEL_WMARK: begin
                  tx_wm <= wr_data[WM_W-1:0];
                  rx_wm <= wr_data[WM_RX_LSB +: WM_W];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      stat_clr = '0;
      if (wr_en && sel == SEL_STAT) stat_clr = wr_data[STK_LO +: STK_N];
   end

   logic unused_wdata;
   assign unused_wdata = ^wr_data;

   // R10: flush bits in a control write produce the pulses next cycle
   p_tx_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_CTRL && wr_data[C_TXFL]) |=> tx_flush);
   p_rx_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_CTRL && wr_data[C_RXFL]) |=> rx_flush);
   p_flush_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == SEL_CTRL) |=> !tx_flush && !rx_flush);
endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags
   import spi_fsu_pkg::*;
#(
   parameter int DEPTH          = 16,
   parameter bit IRQ_REGISTERED = 1'b1,
   localparam int CNT_W         = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tx_count_i,
   input  logic [CNT_W-1:0] rx_count_i,
   input  logic             tx_pop_i,
   input  logic             rx_push_i,
   input  logic             frame_done_i,
   input  logic             busy_i,
   input  logic             wr_en_i,
   input  logic [2:0]       wr_sel_i,
   input  logic [31:0]      wr_data_i,
   output logic [31:0]      status_o,
   output logic [31:0]      fifo_stat_o,
   output logic [31:0]      rx_stat_o,
   output logic             irq_o,
   output logic             tx_dma_req_o,
   output logic             rx_dma_req_o,
   output logic             tx_flush_o,
   output logic             rx_flush_o
);
   localparam int WM_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || DEPTH > 255) begin : g_bad_depth
         $error("spi_fifo_flags: DEPTH must lie in 2..255");
      end
   endgenerate

   logic             mod_en;
   logic [3:0]       ien;
   logic [1:0]       dma_en;
   logic [WM_W-1:0]  tx_wm, rx_wm;
   logic [STK_N-1:0] stat_clr, stk_set, stk_flag;
   logic             tdr, rdr, busy_q;
   logic [3:0]       cause;

   spi_fsu_cfg #(.WM_W(WM_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_sel(wr_sel_i),
      .wr_data(wr_data_i), .mod_en(mod_en), .ien(ien), .dma_en(dma_en),
      .tx_wm(tx_wm), .rx_wm(rx_wm), .tx_flush(tx_flush_o),
      .rx_flush(rx_flush_o), .stat_clr(stat_clr)
   );

   spi_fsu_level #(.CNT_W(CNT_W), .WM_W(WM_W), .ABOVE(1'b0)) u_tx_lvl (
      .count(tx_count_i), .wmark(tx_wm), .hit(tdr)
   );

   spi_fsu_level #(.CNT_W(CNT_W), .WM_W(WM_W), .ABOVE(1'b1)) u_rx_lvl (
      .count(rx_count_i), .wmark(rx_wm), .hit(rdr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= busy_i;
   end

   always_comb begin
      stk_set = '0;
      stk_set[B_FRM - STK_LO] = frame_done_i;
      stk_set[B_XFR - STK_LO] = busy_q & ~busy_i;
      stk_set[B_TXU - STK_LO] = tx_pop_i && (tx_count_i == '0);
      stk_set[B_RXO - STK_LO] = rx_push_i && (rx_count_i == CNT_W'(DEPTH));
   end

   spi_fsu_sticky #(.N(STK_N)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set(stk_set), .clr(stat_clr), .flag(stk_flag)
   );

   always_comb begin
      status_o                   = '0;
      status_o[B_TDR]            = tdr;
      status_o[B_RDR]            = rdr;
      status_o[STK_LO +: STK_N]  = stk_flag;
      status_o[B_BUSY]           = busy_i;

      fifo_stat_o                = '0;
      fifo_stat_o[7:0]           = 8'(tx_count_i);
      fifo_stat_o[23:16]         = 8'(rx_count_i);

      rx_stat_o                  = '0;
      rx_stat_o[1]               = (rx_count_i == '0);
   end

   assign cause = {status_o[B_XFR], status_o[B_FRM],
                   status_o[B_RDR], status_o[B_TDR]} & ien;

   generate
      if (IRQ_REGISTERED) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |cause;
         end
         assign irq_o = irq_q;

         // R8: the line only rises after an enabled cause was present
         p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> $past(|cause));
         p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (|cause) |=> irq_o);
      end else begin : g_irq_comb
         assign irq_o = |cause;
      end
   endgenerate

   assign tx_dma_req_o = mod_en & dma_en[0] & tdr;
   assign rx_dma_req_o = mod_en & dma_en[1] & rdr;

   // R9 / R2: a transmit request implies the level is at or below the mark
   p_txdma_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_dma_req_o |-> (int'(tx_count_i) <= int'(tx_wm)));
   // R3: receive-ready implies the level is above the mark
   p_rdr_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[B_RDR] |-> (int'(rx_count_i) > int'(rx_wm)));
   // R6: overflow flag only rises after a push into a full receive FIFO
   p_rxo_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[B_RXO]) |-> $past(rx_push_i && rx_count_i == CNT_W'(DEPTH)));
endmodule

// File: tb/spi_fifo_flags_test.sv
module spi_fifo_flags_test;
   localparam int DEPTH = 16;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] tx_count = '0, rx_count = '0;
   logic             tx_pop = 0, rx_push = 0, frame_done = 0, busy = 0;
   logic             wr_en = 0;
   logic [2:0]       wr_sel = '0;
   logic [31:0]      wr_data = '0;
   logic [31:0]      status, fifo_stat, rx_stat;
   logic             irq, tx_dma, rx_dma, tx_fl, rx_fl;

   int tests = 0, fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   spi_fifo_flags #(.DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .tx_count_i(tx_count), .rx_count_i(rx_count),
      .tx_pop_i(tx_pop), .rx_push_i(rx_push), .frame_done_i(frame_done),
      .busy_i(busy), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
      .status_o(status), .fifo_stat_o(fifo_stat), .rx_stat_o(rx_stat),
      .irq_o(irq), .tx_dma_req_o(tx_dma), .rx_dma_req_o(rx_dma),
      .tx_flush_o(tx_fl), .rx_flush_o(rx_fl)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] data);
      wr_en = 1; wr_sel = sel; wr_data = data;
      tick();
      wr_en = 0; wr_data = '0;
   endtask

   task automatic t_reset();
      chk("R1 status", status, 32'h1);
      chk("R1 irq", {31'b0, irq}, 0);
      chk("R1 dma", {30'b0, tx_dma, rx_dma}, 0);
      chk("R1 flush", {30'b0, tx_fl, rx_fl}, 0);
      chk("R1 rx_stat", rx_stat, 32'h2);
   endtask

   task automatic t_tx_level();
      wr(3'd4, 32'h0000_0004);
      tx_count = 4; #1 chk("R2 at mark", {31'b0, status[0]}, 1);
      tx_count = 5; #1 chk("R2 above mark", {31'b0, status[0]}, 0);
      tx_count = 0; #1 chk("R2 empty", {31'b0, status[0]}, 1);
   endtask

   task automatic t_rx_level();
      wr(3'd4, 32'h0003_0004);
      rx_count = 3; #1 chk("R3 at mark", {31'b0, status[1]}, 0);
      rx_count = 4; #1 chk("R3 above mark", {31'b0, status[1]}, 1);
      tx_count = 7; #1 chk("R11 counts", fifo_stat, 32'h0004_0007);
      chk("R11 rx not empty", rx_stat, 32'h0);
      tx_count = 0; rx_count = 0;
   endtask

   task automatic t_sticky();
      frame_done = 1; tick(); frame_done = 0;
      chk("R4 frame flag", {31'b0, status[9]}, 1);
      busy = 1; tick();
      chk("R7 busy bit", {31'b0, status[24]}, 1);
      chk("R4 no xfer while busy", {31'b0, status[10]}, 0);
      busy = 0; tick();
      chk("R4 xfer flag", {31'b0, status[10]}, 1);
      wr(3'd1, 32'h0000_0200);
      chk("R5 clear frame only", status & 32'h3F00, 32'h0400);
      wr(3'd1, 32'h0);
      chk("R5 zero write no effect", status & 32'h3F00, 32'h0400);
      frame_done = 1; wr(3'd1, 32'h0000_0200); frame_done = 0;
      chk("R5 set wins", {31'b0, status[9]}, 1);
      wr(3'd1, 32'h0000_3F00);
      chk("R5 clear all", status & 32'h3F00, 0);
   endtask

   task automatic t_errors();
      tx_count = 3; tx_pop = 1; tick(); tx_pop = 0;
      chk("R6 pop nonempty", {31'b0, status[11]}, 0);
      tx_count = 0; tx_pop = 1; tick(); tx_pop = 0;
      chk("R6 underrun", {31'b0, status[11]}, 1);
      rx_count = 15; rx_push = 1; tick(); rx_push = 0;
      chk("R6 push not full", {31'b0, status[12]}, 0);
      rx_count = 16; rx_push = 1; tick(); rx_push = 0;
      chk("R6 overflow", {31'b0, status[12]}, 1);
      rx_count = 0;
      wr(3'd1, 32'h0000_3F00);
   endtask

   task automatic t_irq();
      tx_count = 8;
      wr(3'd2, 32'h0000_0800);
      tx_count = 0; tx_pop = 1; tick(); tx_pop = 0; tx_count = 8;
      tick();
      chk("R8 ignored enable", {31'b0, irq}, 0);
      wr(3'd1, 32'h0000_3F00);
      wr(3'd2, 32'h0000_0200);
      frame_done = 1; tick(); frame_done = 0;
      chk("R8 not yet", {31'b0, irq}, 0);
      tick();
      chk("R8 raised", {31'b0, irq}, 1);
      wr(3'd1, 32'h0000_0200);
      chk("R8 held one cycle", {31'b0, irq}, 1);
      tick();
      chk("R8 dropped", {31'b0, irq}, 0);
      wr(3'd2, 32'h0);
   endtask

   task automatic t_dma();
      wr(3'd4, 32'h0002_0004);
      wr(3'd3, 32'h3);
      tx_count = 2; rx_count = 5; #1
      chk("R9 disabled module", {30'b0, tx_dma, rx_dma}, 0);
      wr(3'd0, 32'h1);
      chk("R9 both requests", {30'b0, tx_dma, rx_dma}, 32'h3);
      tx_count = 9; rx_count = 1; #1
      chk("R9 levels off", {30'b0, tx_dma, rx_dma}, 0);
      tx_count = 0; rx_count = 3; wr(3'd3, 32'h2);
      chk("R9 rx only", {30'b0, tx_dma, rx_dma}, 32'h1);
      wr(3'd0, 32'h0);
      chk("R9 enable off", {30'b0, tx_dma, rx_dma}, 0);
      rx_count = 0;
   endtask

   task automatic t_flush();
      wr(3'd0, 32'h0000_0100);
      chk("R10 tx pulse", {30'b0, tx_fl, rx_fl}, 32'h2);
      tick();
      chk("R10 tx one cycle", {30'b0, tx_fl, rx_fl}, 0);
      wr(3'd0, 32'h0000_0200);
      chk("R10 rx pulse", {30'b0, tx_fl, rx_fl}, 32'h1);
      tick();
      chk("R10 rx one cycle", {30'b0, tx_fl, rx_fl}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_tx_level();
      t_rx_level();
      t_sticky();
      t_errors();
      t_irq();
      t_dma();
      t_flush();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule